// File: doc/BRIEF.md
# Bit-Addressed Serial I/O Peripheral

This block attaches to a processor's single-bit I/O port. It provides 32 output bits and 32 input bits, and it moves exactly one bit for each access. The processor places an I/O address on the parallel address bus. The upper field of that address selects the device, and the lower field picks one bit inside it.

On an output access, the processor also pulses a clock-strobe line and puts the value to store on a separate output-data line. During the same cycle, the block returns the addressed input bit on an input-data line, together with an output enable.

The processor also issues external-command cycles. These pulse the same strobe but set the three most significant address lines to a non-zero value. The block rejects these cycles even when the rest of the address happens to match its base. The strobe is qualified by those three lines being zero, so that a control instruction cannot be mistaken for an I/O write.

Everything is sampled on the rising edge of the system clock, and both outputs are registered.

The address bus `abus` is 15 bits wide, and address line k is carried on `abus[14-k]`:
- Address line 0, the most significant, is on `abus[14]`.
- The qualifier lines 0 to 2 are `abus[14:12]`.
- The select field, lines 0 to 9, is `abus[14:5]`.
- The bit index, lines 10 to 14, is `abus[4:0]`. Line 10 is the index MSB.

Top module: `bitio_port`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 `out_bits`, `din_oe` and `din_line` to 0 at the next rising edge.
- R2: At a rising edge where `strobe` is 1 and `abus[14:5]` equals `BASE`, bit `abus[4:0]` of `out_bits` takes the value of `dout_line`.
- R3: At such a write edge, every other bit of `out_bits` keeps its value, so no more than one bit changes per edge.
- R4: A strobe with any of `abus[14:12]` non-zero leaves `out_bits` unchanged, even when `abus[11:5]` equals `BASE[6:0]`.
- R5: With `strobe` at 0, `out_bits` does not change, whatever the address and `dout_line` hold.
- R6: A strobe while `abus[14:5]` differs from `BASE` leaves `out_bits` unchanged.
- R7: After a rising edge where `abus[14:5]` equals `BASE`, `din_oe` is 1 and `din_line` equals `in_bits[abus[4:0]]` as sampled at that edge, whether or not `strobe` is set.
- R8: After a rising edge where `abus[14:5]` differs from `BASE`, both `din_oe` and `din_line` are 0.
- R9: The bit index is the binary value of `abus[4:0]`, with `abus[4]` (address line 10) as its most significant bit. Index 0 addresses `out_bits[0]` and `in_bits[0]`, and index 31 addresses bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| abus | input | 15 | I/O address; address line k on bit 14-k |
| dout_line | input | 1 | Output-data line: the value to store on a write |
| strobe | input | 1 | Clock-strobe from the processor, one cycle per access |
| in_bits | input | 32 | Input bits offered to the processor |
| out_bits | output | 32 | Output latch bank |
| din_line | output | 1 | Registered input-data line, low when not selected |
| din_oe | output | 1 | Registered drive enable for the shared input-data line |

## Verification
The hardest case to provoke is an external-command cycle that looks exactly like a write to this device. In that cycle the seven lower select lines match the base, only the three qualifier lines are non-zero, and the data on the output-data line differs from what is stored. To create it, the stimulus builds addresses from `BASE[6:0]` with each of the seven non-zero qualifier patterns. It sets the data line to the inverse of the modelled latch value and raises the strobe. Any leak through the qualification gate then flips a visible output bit. Writes to foreign bases are driven the same way, and so are selected cycles without a strobe.

// File: rtl/bitio_pkg.sv
`timescale 1ns/1ps
package bitio_pkg;
  // Default field widths of the I/O address
  localparam int unsigned SEL_W_D  = 10;  // device-select field
  localparam int unsigned IDX_W_D  = 5;   // bit-index field
  localparam int unsigned QUAL_W_D = 3;   // lines that must be zero on an I/O cycle

  // One decoded access as seen by the latch bank and the return path
  typedef struct packed {
    logic       sel;   // device addressed on a genuine I/O cycle
    logic       wr;    // qualified write strobe
  } acc_ctl_t;
endpackage

// File: rtl/bitio_decode.sv
`timescale 1ns/1ps
module bitio_decode
  import bitio_pkg::*;
#(
  parameter int unsigned     SEL_W  = SEL_W_D,
  parameter int unsigned     IDX_W  = IDX_W_D,
  parameter int unsigned     QUAL_W = QUAL_W_D,
  parameter logic [SEL_W-1:0] BASE  = '0
) (
  input  logic [SEL_W+IDX_W-1:0] abus,
  input  logic                   strobe,
  output acc_ctl_t               ctl,
  output logic [IDX_W-1:0]       idx
);
  localparam int unsigned AW    = SEL_W + IDX_W;
  localparam int unsigned LOW_W = SEL_W - QUAL_W;

  logic             io_cycle;
  logic [SEL_W-1:0] field;
  logic             match;

  // The qualifier lines are zero on every genuine I/O cycle.
  assign io_cycle = ~|abus[AW-1 -: QUAL_W];

  // The select field is compared with the qualifier lines forced to zero,
  // so the qualification gate alone keeps command cycles out.
  assign field = {{QUAL_W{1'b0}}, abus[AW-QUAL_W-1 -: LOW_W]};
  assign match = (field == BASE);

  assign idx     = abus[IDX_W-1:0];
  assign ctl.sel = match & io_cycle;
  assign ctl.wr  = strobe & match & io_cycle;
endmodule

// File: rtl/bitio_latch_bank.sv
`timescale 1ns/1ps
module bitio_latch_bank #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned NBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             d,
  output logic [NBITS-1:0] q
);
  // One flop per bit, each with its own write enable.
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic hit;
    assign hit = wr && (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)      q[i] <= 1'b0;
      else if (hit) q[i] <= d;
    end
  end
endmodule

// File: rtl/bitio_in_mux.sv
`timescale 1ns/1ps
module bitio_in_mux #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned NBITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  input  logic [NBITS-1:0] in_bits,
  output logic             din_line,
  output logic             din_oe
);
  logic pick;
  assign pick = in_bits[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      din_oe   <= 1'b0;
      din_line <= 1'b0;
    end else begin
      din_oe   <= sel;
      din_line <= sel & pick;
    end
  end
endmodule

// File: rtl/bitio_port.sv
`timescale 1ns/1ps
module bitio_port
  import bitio_pkg::*;
#(
  parameter int unsigned      SEL_W  = SEL_W_D,
  parameter int unsigned      IDX_W  = IDX_W_D,
  parameter int unsigned      QUAL_W = QUAL_W_D,
  parameter logic [SEL_W-1:0] BASE   = 10'h02C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEL_W+IDX_W-1:0]  abus,
  input  logic                    dout_line,
  input  logic                    strobe,
  input  logic [(1<<IDX_W)-1:0]   in_bits,
  output logic [(1<<IDX_W)-1:0]   out_bits,
  output logic                    din_line,
  output logic                    din_oe
);
  localparam int unsigned NBITS = 1 << IDX_W;

  acc_ctl_t         ctl;
  logic [IDX_W-1:0] idx;

  bitio_decode #(
    .SEL_W (SEL_W),
    .IDX_W (IDX_W),
    .QUAL_W(QUAL_W),
    .BASE  (BASE)
  ) i_decode (
    .abus  (abus),
    .strobe(strobe),
    .ctl   (ctl),
    .idx   (idx)
  );

  bitio_latch_bank #(
    .IDX_W(IDX_W),
    .NBITS(NBITS)
  ) i_bank (
    .clk(clk),
    .rst(rst),
    .wr (ctl.wr),
    .idx(idx),
    .d  (dout_line),
    .q  (out_bits)
  );

  bitio_in_mux #(
    .IDX_W(IDX_W),
    .NBITS(NBITS)
  ) i_ret (
    .clk     (clk),
    .rst     (rst),
    .sel     (ctl.sel),
    .idx     (idx),
    .in_bits (in_bits),
    .din_line(din_line),
    .din_oe  (din_oe)
  );
endmodule

// File: rtl/bitio_port_chk.sv
`timescale 1ns/1ps
module bitio_port_chk #(
  parameter logic [9:0] BASE = 10'h02C
) (
  input logic        clk,
  input logic        rst,
  input logic [14:0] abus,
  input logic        dout_line,
  input logic        strobe,
  input logic [31:0] in_bits,
  input logic [31:0] out_bits,
  input logic        din_line,
  input logic        din_oe
);
  logic [4:0] c_idx;
  logic       c_hit;
  assign c_idx = abus[4:0];
  assign c_hit = (abus[14:5] == BASE);

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && c_hit) |=> out_bits[$past(c_idx)] == $past(dout_line));

  // R3
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> $countones(out_bits ^ $past(out_bits)) <= 1);

  // R4
  ext_cmd_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && (abus[14:12] != 3'b000)) |=> $stable(out_bits));

  // R5
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(out_bits));

  // R6
  foreign_base_chk: assert property (@(posedge clk) disable iff (rst)
    !c_hit |=> $stable(out_bits));

  // R7
  read_return_chk: assert property (@(posedge clk) disable iff (rst)
    c_hit |=> din_oe && (din_line == $past(in_bits[c_idx])));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !c_hit |=> !din_oe && !din_line);
endmodule

bind bitio_port bitio_port_chk #(.BASE(BASE)) i_bitio_port_chk (
  .clk      (clk),
  .rst      (rst),
  .abus     (abus),
  .dout_line(dout_line),
  .strobe   (strobe),
  .in_bits  (in_bits),
  .out_bits (out_bits),
  .din_line (din_line),
  .din_oe   (din_oe)
);

// File: tb/test_bitio_port.sv
`timescale 1ns/1ps
module test_bitio_port;
  localparam logic [9:0]  BASE = 10'h02C;
  localparam logic [31:0] PAT  = 32'h9E37_61B5;

  logic        clk = 1'b0;
  logic        rst;
  logic [14:0] abus;
  logic        dout_line;
  logic        strobe;
  logic [31:0] in_bits;
  logic [31:0] out_bits;
  logic        din_line;
  logic        din_oe;

  always #2 clk = ~clk;

  bitio_port #(.BASE(BASE)) i_bitio_port (
    .clk(clk), .rst(rst), .abus(abus), .dout_line(dout_line),
    .strobe(strobe), .in_bits(in_bits), .out_bits(out_bits),
    .din_line(din_line), .din_oe(din_oe)
  );

  typedef struct {
    logic        oe;
    logic        line;
    logic [31:0] outs;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] model;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;

  function automatic logic [14:0] mk(input logic [2:0] q, input logic [6:0] lo,
                                     input logic [4:0] ix);
    return {q, lo, ix};
  endfunction

  task automatic compare(input string req, input logic oe, input logic line,
                         input logic [31:0] outs);
    checks++;
    if (din_oe !== oe || din_line !== line || out_bits !== outs) begin
      errors++;
      $display("FAIL %s: oe=%b line=%b outs=%h expected oe=%b line=%b outs=%h",
               req, din_oe, din_line, out_bits, oe, line, outs);
    end
  endtask

  // Driver: applies one access and pushes what it must produce
  task automatic access(input logic [14:0] a, input logic d, input logic s,
                        input logic [31:0] ib, input string req);
    exp_t e;
    logic sel;
    int   ix;
    @(negedge clk);
    abus = a; dout_line = d; strobe = s; in_bits = ib;
    sel = (a[14:5] == BASE);
    ix  = int'(a[4:0]);
    if (sel && s) model[ix] = d;
    e.oe   = sel;
    e.line = sel ? ib[ix] : 1'b0;
    e.outs = model;
    e.req  = req;
    sbq.push_back(e);
  endtask

  // Monitor: compares one result after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        compare(e.req, e.oe, e.line, e.outs);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = '0;
    compare("R1 reset", 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    rst = 1'b1; abus = '0; dout_line = 1'b0; strobe = 1'b0; in_bits = '0;
    model = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset", 1'b0, 1'b0, 32'h0);

    // R2 R3 R9: walk every index with a pattern
    for (int i = 0; i < 32; i++)
      access(mk(3'b000, BASE[6:0], 5'(i)), PAT[i], 1'b1, 32'h0, "R2 R3 R9 write");

    // R5 R7: selected reads with no strobe and opposite data
    for (int i = 0; i < 32; i++)
      access(mk(3'b000, BASE[6:0], 5'(i)), ~PAT[i], 1'b0, ~PAT ^ (32'h1 << i),
             "R5 R7 read");

    // R4: command cycles whose lower select lines match the base
    for (int q = 1; q < 8; q++)
      for (int k = 0; k < 4; k++) begin
        int ix;
        ix = (q * 5 + k * 9) % 32;
        access(mk(3'(q), BASE[6:0], 5'(ix)), ~model[ix], 1'b1, PAT, "R4 command");
      end

    // R6 R8: strobes at foreign bases
    access({BASE ^ 10'h001, 5'd3},  ~model[3],  1'b1, PAT, "R6 R8 foreign");
    access({BASE ^ 10'h010, 5'd17}, ~model[17], 1'b1, PAT, "R6 R8 foreign");
    access({BASE ^ 10'h07F, 5'd31}, ~model[31], 1'b1, PAT, "R6 R8 foreign");

    // R3: single toggles on both ends
    access(mk(3'b000, BASE[6:0], 5'd0),  ~model[0],  1'b1, 32'h0000_0001, "R3 toggle");
    access(mk(3'b000, BASE[6:0], 5'd31), ~model[31], 1'b1, 32'h8000_0000, "R3 toggle");

    // R8: idle on another device
    access({BASE ^ 10'h004, 5'd9}, 1'b1, 1'b0, 32'hFFFF_FFFF, "R8 idle");

    // R1: reset in mid-run, then one write
    do_reset();
    access(mk(3'b000, BASE[6:0], 5'd12), 1'b1, 1'b1, 32'h0000_1000, "R2 R7 after reset");
    access(mk(3'b000, BASE[6:0], 5'd12), 1'b0, 1'b0, 32'h0, "R5 R7 after reset");

    @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule